// File: doc/BRIEF.md
# Mixed-Precision Compare Condition Unit

This block compares two numeric operands and packs the outcome into one 32-bit condition word. A later branch or bit-test instruction reads that word one bit at a time. Each operand comes with its own format tag, so the two sides of one compare may use different formats. The supported formats are IEEE binary32, IEEE binary64, signed 32-bit integer and unsigned 32-bit integer. A 64-bit operand is supplied as two 32-bit halves. It comes with the register index it was read from and a flag that marks an immediate source, so the block can reject an illegal register pair or immediate.

Both operands are widened without loss to binary64 and then mapped to an unsigned ordering key, and the keys are compared. The word holds:
- an ordered or unordered indication;
- six relational flags (equal, not equal, greater, less-or-equal, less, greater-or-equal);
- four range flags that place the first operand against the interval from zero to the second operand.

An operand fault clears the word and raises an error flag. The result is registered and appears one clock after the request.

Top module: `fcmp_cond_unit`

## Requirements
- R1: A request sampled with `req_vld` high gives `rsp_vld` high on the next clock, with that request's word and error flag. A cycle without a request gives `rsp_vld` low. Reset (async, active low) drives all outputs to zero.
- R2: Tag 0 = binary32 in `*_lo`, 1 = binary64 as {`*_hi`,`*_lo`}, 2 = signed int32 in `*_lo`, 3 = unsigned int32 in `*_lo`. Every format is compared by exact numeric value, including across different formats.
- R3: If either operand is a NaN, the word is exactly bit 30 set, and bit 31 and bits 29..20 are clear.
- R4: With no NaN, bit 31 is set. Bits 20..25 are set for s1==s2, s1!=s2, s1>s2, s1<=s2, s1<s2 and s1>=s2 respectively.
- R5: With no NaN, bit 26 = (s1<0 or s1>s2) and bit 27 = (0<s1 and s1<s2).
- R6: With no NaN, bit 28 = (0<=s1 and s1<=s2) and bit 29 = (s1<=0 or s1>=s2).
- R7: +0 and -0 compare equal. Infinities order by sign. Binary32 subnormals keep their exact value.
- R8: A tag of 4..7 on either operand raises `rsp_err` with a zero word. An error takes priority over a NaN.
- R9: A binary64 operand read from registers needs an even index of at least 2. An odd index or index 0 raises `rsp_err` with a zero word. The even register supplies the low half.
- R10: A binary64 operand flagged as immediate raises `rsp_err` with a zero word. A 32-bit operand flagged as immediate is legal.
- R11: Bits 19..0 of `rsp_cond` are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_vld | input | 1 | Request strobe |
| s1_prec | input | 3 | Format tag of operand 1 |
| s1_imm | input | 1 | Operand 1 is an immediate |
| s1_ridx | input | 5 | Register index of operand 1 |
| s1_hi | input | 32 | Upper half of operand 1 (binary64 only) |
| s1_lo | input | 32 | Lower half or 32-bit value of operand 1 |
| s2_prec | input | 3 | Format tag of operand 2 |
| s2_imm | input | 1 | Operand 2 is an immediate |
| s2_ridx | input | 5 | Register index of operand 2 |
| s2_hi | input | 32 | Upper half of operand 2 (binary64 only) |
| s2_lo | input | 32 | Lower half or 32-bit value of operand 2 |
| rsp_vld | output | 1 | Result strobe, one clock after request |
| rsp_cond | output | 32 | Condition word |
| rsp_err | output | 1 | Operand fault |

## Verification
The only state is the output register, so any fault shows at the ports on the clock after the request that caused it. A wrong widening step or a wrong ordering key shows up as a swapped or missing relation bit on mixed-format pairs, on subnormals and on the two zeros. A wrong fault decode shows up as a nonzero word next to `rsp_err`, or as a clean result for an illegal pair. Consistency rules make many single-bit faults visible on any ordered result: exactly one of equal, less or greater is set, and each flag is paired with its complement.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    localparam int WORD_W = 32;
    localparam int KEY_W  = 64;

    // operand format tags
    localparam logic [2:0] FMT_F32 = 3'd0;
    localparam logic [2:0] FMT_F64 = 3'd1;
    localparam logic [2:0] FMT_I32 = 3'd2;
    localparam logic [2:0] FMT_U32 = 3'd3;

    // condition word bit positions
    localparam int B_ORD   = 31;
    localparam int B_UNORD = 30;
    localparam int B_EQ    = 20;
    localparam int B_NE    = 21;
    localparam int B_GT    = 22;
    localparam int B_LE    = 23;
    localparam int B_LT    = 24;
    localparam int B_GE    = 25;
    localparam int B_OUT   = 26;
    localparam int B_IN    = 27;
    localparam int B_INC   = 28;
    localparam int B_NIN   = 29;

    typedef struct packed {
        logic        sign;
        logic [10:0] expo;
        logic [51:0] frac;
    } f64_t;

    typedef struct packed {
        logic              vld;
        logic              err;
        logic [WORD_W-1:0] cond;
    } rsp_t;

    function automatic logic [5:0] lead_one(input logic [31:0] v);
        logic [5:0] r;
        r = '0;
        for (int i = 0; i < 32; i++) begin
            if (v[i]) r = 6'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/fcmp_opnd_cvt.sv
module fcmp_opnd_cvt
    import fcmp_pkg::*;
#(
    parameter int PREC_W = 3,
    parameter int IDX_W  = 5
) (
    input  logic [PREC_W-1:0] prec,
    input  logic              imm,
    input  logic [IDX_W-1:0]  ridx,
    input  logic [31:0]       hi,
    input  logic [31:0]       lo,
    output logic [KEY_W-1:0]  key,
    output logic              is_nan,
    output logic              is_zero,
    output logic              is_neg,
    output logic              err
);

    localparam logic [IDX_W-1:0] MIN_IDX = IDX_W'(2);

    f64_t        w;
    logic [31:0] mag;
    logic [5:0]  lpos;
    logic [63:0] shl;

    // fault decode
    always_comb begin
        err = 1'b0;
        if (prec > PREC_W'(3)) begin
            err = 1'b1;
        end else if (prec == PREC_W'(FMT_F64)) begin
            if (imm) err = 1'b1;
            else if (ridx[0] || ridx < MIN_IDX) err = 1'b1;
        end
    end

    // widening to binary64
    always_comb begin
        w    = '0;
        mag  = '0;
        lpos = '0;
        shl  = '0;
        case (prec[1:0])
            2'd0: begin
                w.sign = lo[31];
                if (lo[30:23] == 8'hFF) begin
                    w.expo = 11'h7FF;
                    w.frac = {lo[22:0], 29'b0};
                end else if (lo[30:23] == 8'h00) begin
                    if (lo[22:0] != 23'b0) begin
                        lpos   = lead_one({9'b0, lo[22:0]});
                        shl    = {41'b0, lo[22:0]} << (7'd52 - {1'b0, lpos});
                        w.expo = 11'd874 + 11'(lpos);
                        w.frac = shl[51:0];
                    end
                end else begin
                    w.expo = 11'(lo[30:23]) + 11'd896;
                    w.frac = {lo[22:0], 29'b0};
                end
            end
            2'd1: begin
                w.sign = hi[31];
                w.expo = hi[30:20];
                w.frac = {hi[19:0], lo};
            end
            default: begin
                if (prec[1:0] == 2'd2 && lo[31]) begin
                    w.sign = 1'b1;
                    mag    = (~lo) + 32'd1;
                end else begin
                    mag    = lo;
                end
                if (mag != 32'b0) begin
                    lpos   = lead_one(mag);
                    shl    = {32'b0, mag} << (7'd52 - {1'b0, lpos});
                    w.expo = 11'd1023 + 11'(lpos);
                    w.frac = shl[51:0];
                end
            end
        endcase
    end

    // ordering key: unsigned compare of keys matches numeric order
    always_comb begin
        is_nan  = (w.expo == 11'h7FF) && (w.frac != 52'b0);
        is_zero = (w.expo == 11'h000) && (w.frac != 52'b0) ? 1'b0 :
                  (w.expo == 11'h000);
        is_neg  = w.sign && !is_zero;
        if (is_zero)     key = {1'b1, 63'b0};
        else if (w.sign) key = {1'b0, ~{w.expo, w.frac}};
        else             key = {1'b1, w.expo, w.frac};
    end

endmodule

// File: rtl/fcmp_flag_gen.sv
module fcmp_flag_gen
    import fcmp_pkg::*;
(
    input  logic [KEY_W-1:0]  k1,
    input  logic              nan1,
    input  logic              zero1,
    input  logic              neg1,
    input  logic              err1,
    input  logic [KEY_W-1:0]  k2,
    input  logic              nan2,
    input  logic              err2,
    output logic [WORD_W-1:0] cond,
    output logic              err
);

    logic lt, eq, gt, pos1;

    always_comb begin
        lt   = k1 < k2;
        eq   = k1 == k2;
        gt   = !lt && !eq;
        pos1 = !neg1 && !zero1;
        err  = err1 || err2;
        cond = '0;
        if (err) begin
            cond = '0;
        end else if (nan1 || nan2) begin
            cond[B_UNORD] = 1'b1;
        end else begin
            cond[B_ORD] = 1'b1;
            cond[B_EQ]  = eq;
            cond[B_NE]  = !eq;
            cond[B_GT]  = gt;
            cond[B_LE]  = !gt;
            cond[B_LT]  = lt;
            cond[B_GE]  = !lt;
            cond[B_OUT] = neg1 || gt;
            cond[B_IN]  = pos1 && lt;
            cond[B_INC] = !neg1 && !gt;
            cond[B_NIN] = !pos1 || !lt;
        end
    end

endmodule

// File: rtl/fcmp_cond_unit.sv
module fcmp_cond_unit
    import fcmp_pkg::*;
#(
    parameter int PREC_W = 3,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic [PREC_W-1:0] s1_prec,
    input  logic              s1_imm,
    input  logic [IDX_W-1:0]  s1_ridx,
    input  logic [31:0]       s1_hi,
    input  logic [31:0]       s1_lo,
    input  logic [PREC_W-1:0] s2_prec,
    input  logic              s2_imm,
    input  logic [IDX_W-1:0]  s2_ridx,
    input  logic [31:0]       s2_hi,
    input  logic [31:0]       s2_lo,
    output logic              rsp_vld,
    output logic [31:0]       rsp_cond,
    output logic              rsp_err
);

    localparam int NOPS = 2;

    logic [PREC_W-1:0] op_prec [NOPS];
    logic              op_imm  [NOPS];
    logic [IDX_W-1:0]  op_ridx [NOPS];
    logic [31:0]       op_hi   [NOPS];
    logic [31:0]       op_lo   [NOPS];
    logic [KEY_W-1:0]  op_key  [NOPS];
    logic              op_nan  [NOPS];
    logic              op_zero [NOPS];
    logic              op_neg  [NOPS];
    logic              op_err  [NOPS];

    always_comb begin
        op_prec[0] = s1_prec; op_imm[0] = s1_imm; op_ridx[0] = s1_ridx;
        op_hi[0]   = s1_hi;   op_lo[0]  = s1_lo;
        op_prec[1] = s2_prec; op_imm[1] = s2_imm; op_ridx[1] = s2_ridx;
        op_hi[1]   = s2_hi;   op_lo[1]  = s2_lo;
    end

    for (genvar g = 0; g < NOPS; g++) begin : g_cvt
        fcmp_opnd_cvt #(.PREC_W(PREC_W), .IDX_W(IDX_W)) cvt_i (
            .prec    (op_prec[g]),
            .imm     (op_imm[g]),
            .ridx    (op_ridx[g]),
            .hi      (op_hi[g]),
            .lo      (op_lo[g]),
            .key     (op_key[g]),
            .is_nan  (op_nan[g]),
            .is_zero (op_zero[g]),
            .is_neg  (op_neg[g]),
            .err     (op_err[g])
        );
    end

    logic [WORD_W-1:0] cond_w;
    logic              err_w;

    fcmp_flag_gen flag_i (
        .k1    (op_key[0]),
        .nan1  (op_nan[0]),
        .zero1 (op_zero[0]),
        .neg1  (op_neg[0]),
        .err1  (op_err[0]),
        .k2    (op_key[1]),
        .nan2  (op_nan[1]),
        .err2  (op_err[1]),
        .cond  (cond_w),
        .err   (err_w)
    );

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d = '0;
        if (req_vld) begin
            rsp_d.vld  = 1'b1;
            rsp_d.err  = err_w;
            rsp_d.cond = cond_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_vld  = rsp_q.vld;
    assign rsp_cond = rsp_q.cond;
    assign rsp_err  = rsp_q.err;

endmodule

// File: rtl/fcmp_cond_unit_chk.sv
module fcmp_cond_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_vld,
    input logic        rsp_vld,
    input logic [31:0] rsp_cond,
    input logic        rsp_err
);

    // R1
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> rsp_vld);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> (!rsp_vld && !rsp_err && rsp_cond == 32'b0));

    // R11
    low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_cond[19:0] == 20'b0);

    // R3
    unord_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && rsp_cond[30]) |-> (rsp_cond[31:20] == 12'h400));

    // R4
    ord_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && !rsp_err) |-> ($countones(rsp_cond[31:30]) == 1));

    // R4
    rel_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_cond[31] |-> ($countones({rsp_cond[20], rsp_cond[22], rsp_cond[24]}) == 1
                          && rsp_cond[21] == !rsp_cond[20]
                          && rsp_cond[23] == !rsp_cond[22]
                          && rsp_cond[25] == !rsp_cond[24]));

    // R6
    range_dual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_cond[31] |-> (rsp_cond[28] == !rsp_cond[26] && rsp_cond[29] == !rsp_cond[27]));

    // R5
    inside_lt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_cond[27] |-> rsp_cond[24]);

    // R8
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_vld && rsp_cond == 32'b0));

endmodule

bind fcmp_cond_unit fcmp_cond_unit_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_vld  (req_vld),
    .rsp_vld  (rsp_vld),
    .rsp_cond (rsp_cond),
    .rsp_err  (rsp_err)
);

// File: tb/fcmp_cond_unit_tb_top.sv
module fcmp_cond_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0;
    logic [2:0]  s1_prec = '0, s2_prec = '0;
    logic        s1_imm = 1'b0, s2_imm = 1'b0;
    logic [4:0]  s1_ridx = '0, s2_ridx = '0;
    logic [31:0] s1_hi = '0, s1_lo = '0, s2_hi = '0, s2_lo = '0;
    logic        rsp_vld;
    logic [31:0] rsp_cond;
    logic        rsp_err;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    fcmp_cond_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld),
        .s1_prec(s1_prec), .s1_imm(s1_imm), .s1_ridx(s1_ridx), .s1_hi(s1_hi), .s1_lo(s1_lo),
        .s2_prec(s2_prec), .s2_imm(s2_imm), .s2_ridx(s2_ridx), .s2_hi(s2_hi), .s2_lo(s2_lo),
        .rsp_vld(rsp_vld), .rsp_cond(rsp_cond), .rsp_err(rsp_err)
    );

    // relation codes: 0 lt, 1 eq, 2 gt, 3 unordered; sign of s1: 0 neg, 1 zero, 2 pos
    typedef struct packed {
        logic [2:0]  ap; logic ai; logic [4:0] ax; logic [31:0] ah; logic [31:0] al;
        logic [2:0]  bp; logic bi; logic [4:0] bx; logic [31:0] bh; logic [31:0] bl;
        logic [1:0]  rel; logic [1:0] sg; logic err; logic [3:0] req;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VECS [NV] = '{
        '{0,0,0,0,32'h3F800000, 0,0,0,0,32'h40000000, 0,2,0,4},   // R4 1<2
        '{0,0,0,0,32'h40000000, 0,0,0,0,32'h3F800000, 2,2,0,4},   // R4 2>1
        '{0,0,0,0,32'hBF800000, 0,0,0,0,32'h3F800000, 0,0,0,5},   // R5 -1<1
        '{0,0,0,0,32'h00000000, 0,0,0,0,32'h80000000, 1,1,0,7},   // R7 +0==-0
        '{0,0,0,0,32'h7FC00000, 0,0,0,0,32'h3F800000, 3,0,0,3},   // R3 NaN s1
        '{0,0,0,0,32'h3F800000, 1,0,2,32'h7FF80000,0, 3,0,0,3},   // R3 NaN s2 double
        '{2,0,0,0,32'hFFFFFFFB, 3,0,0,0,32'h00000003, 0,0,0,2},   // R2 -5<3u
        '{3,0,0,0,32'hFFFFFFFF, 2,0,0,0,32'hFFFFFFFF, 2,2,0,2},   // R2 4294967295>-1
        '{1,0,4,32'h3FF00000,0, 0,0,0,0,32'h3F800000, 1,2,0,2},   // R2 d1==s1
        '{0,0,0,0,32'h7F800000, 1,0,6,32'h7FF00000,0, 1,2,0,7},   // R7 +inf
        '{0,0,0,0,32'hFF800000, 2,0,0,0,32'h80000000, 0,0,0,7},   // R7 -inf<-2^31
        '{0,0,0,0,32'h00000001, 0,0,0,0,32'h00000002, 0,2,0,7},   // R7 subnormals
        '{0,0,0,0,32'h00000001, 1,0,8,32'h36A00000,0, 1,2,0,7},   // R7 2^-149
        '{0,0,0,0,32'h00400000, 1,0,8,32'h38000000,0, 1,2,0,7},   // R7 2^-127
        '{2,0,0,0,32'h00000007, 0,0,0,0,32'h40E00000, 1,2,0,2},   // R2 7==7.0
        '{3,0,0,0,32'h00000000, 0,0,0,0,32'h80000000, 1,1,0,7},   // R7 0u==-0
        '{2,0,0,0,32'h01000001, 0,0,0,0,32'h4B800000, 2,2,0,2},   // R2 exact 2^24+1
        '{1,0,10,32'h3FF00000,32'h1, 1,0,12,32'h3FF00000,0, 2,2,0,9}, // R9 low half
        '{3,0,0,0,32'h00000000, 0,0,0,0,32'h3F800000, 0,1,0,6},   // R6 0<1
        '{0,0,0,0,32'hBF800000, 0,0,0,0,32'hC0000000, 2,0,0,5},   // R5 -1>-2
        '{0,1,0,0,32'h3F800000, 0,0,0,0,32'h3F800000, 1,2,0,10},  // R10 single imm ok
        '{1,0,3,32'h3FF00000,0, 0,0,0,0,32'h3F800000, 0,0,1,9},   // R9 odd
        '{0,0,0,0,32'h3F800000, 1,0,0,32'h3FF00000,0, 0,0,1,9},   // R9 idx0
        '{1,1,0,32'h3FF00000,0, 0,0,0,0,32'h3F800000, 0,0,1,10},  // R10 double imm
        '{5,0,0,0,32'h3F800000, 0,0,0,0,32'h3F800000, 0,0,1,8},   // R8 tag5
        '{0,0,0,0,32'h3F800000, 7,0,0,0,32'h3F800000, 0,0,1,8},   // R8 tag7
        '{0,0,0,0,32'h7FC00000, 4,0,0,0,32'h3F800000, 0,0,1,8},   // R8 err over NaN
        '{1,0,14,32'h40040000,0, 1,0,16,32'hC0080000,0, 2,2,0,2}, // R2 2.5>-3
        '{0,0,0,0,32'h3F000000, 0,0,0,0,32'h3F800000, 0,2,0,6},   // R6 inside
        '{0,0,0,0,32'h00000000, 0,0,0,0,32'hBF800000, 2,1,0,6},   // R6 0>-1
        '{0,0,0,0,32'hFF800000, 0,0,0,0,32'hFF800000, 1,0,0,7}    // R7 -inf==-inf
    };

    function automatic logic [31:0] exp_word(input logic [1:0] rel, input logic [1:0] sg, input logic err);
        logic [31:0] r;
        logic lt, eq, gt, neg, pos;
        r = '0;
        if (err) return r;
        if (rel == 2'd3) begin r[30] = 1'b1; return r; end
        lt = rel == 2'd0; eq = rel == 2'd1; gt = rel == 2'd2;
        neg = sg == 2'd0; pos = sg == 2'd2;
        r[31] = 1'b1;
        r[20] = eq; r[21] = !eq; r[22] = gt; r[23] = !gt; r[24] = lt; r[25] = !lt;
        r[26] = neg || gt;       // R5
        r[27] = pos && lt;       // R5
        r[28] = !neg && !gt;     // R6
        r[29] = !pos || !lt;     // R6
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic drive(input vec_t v);
        req_vld = 1'b1;
        s1_prec = v.ap; s1_imm = v.ai; s1_ridx = v.ax; s1_hi = v.ah; s1_lo = v.al;
        s2_prec = v.bp; s2_imm = v.bi; s2_ridx = v.bx; s2_hi = v.bh; s2_lo = v.bl;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset vld", {31'b0, rsp_vld}, 32'd0);
        check("R1 reset cond", rsp_cond, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle vld", {31'b0, rsp_vld}, 32'd0);

        // back-to-back vector walk
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            check($sformatf("R1 vld vec%0d", i), {31'b0, rsp_vld}, 32'd1);
            check($sformatf("R%0d err vec%0d", VECS[i].req, i), {31'b0, rsp_err}, {31'b0, VECS[i].err});
            check($sformatf("R%0d cond vec%0d", VECS[i].req, i), rsp_cond,
                  exp_word(VECS[i].rel, VECS[i].sg, VECS[i].err));
            check($sformatf("R11 low bits vec%0d", i), {12'b0, rsp_cond[19:0]}, 32'd0);
        end

        // R1 gap: no request gives no result
        req_vld = 1'b0;
        @(negedge clk);
        check("R1 gap vld", {31'b0, rsp_vld}, 32'd0);
        check("R11 gap cond", rsp_cond, 32'd0);

        // R8 error result then idle: error does not linger
        drive(VECS[24]);
        @(negedge clk);
        check("R8 err set", {31'b0, rsp_err}, 32'd1);
        req_vld = 1'b0;
        @(negedge clk);
        check("R8 err clears", {31'b0, rsp_err}, 32'd0);

        // R1 reset mid-stream clears a held result
        drive(VECS[0]);
        @(negedge clk);
        check("R1 pre-reset vld", {31'b0, rsp_vld}, 32'd1);
        req_vld = 1'b0;
        rst_n = 1'b0;
        #1;
        check("R1 async reset vld", {31'b0, rsp_vld}, 32'd0);
        check("R1 async reset cond", rsp_cond, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end

endmodule